// File: doc/BRIEF.md
# Address-masked GPIO data port

This block is a small general-purpose I/O port of eight pins, reached through a byte-wide register bus. It has two registers: a data register holding the values driven on output pins, and a direction register that sets each pin as an output or an input. Every pin has an output value, an output enable and an input. Inputs pass through a two-stage synchroniser before software can read them.

The data register fills a whole window of offsets. Address bits [9:2] of a data access act as a pin mask. A write changes only the pins whose mask bit is set. A read returns the live pin values in the masked positions and zero in all others. Software can therefore set, clear or sample any group of pins in a single bus access, with no read-modify-write sequence and no race against other agents using other pins. The direction register sits at one fixed offset and is written as a whole byte.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, pin_out, pin_oe and rdata are all zero, so every pin starts as an input with a stored value of zero.
- R2: An access is a data access when bits [11:10] and [1:0] of the address are all zero. Its pin mask is address bits [9:2]: bit n of the mask, held in address bit n+2, selects pin n. Offset 0x3FC selects all eight pins, and offset 1 << (n+2) selects pin n alone.
- R3: A data write loads wdata bit n into stored value n for every pin whose mask bit is set, and leaves the stored values of all other pins unchanged.
- R4: A read returns its result on rdata in the cycle after rd_en. For a data read, bit n is the value of pin n when mask bit n is set and zero when it is clear. In any cycle that follows a cycle without rd_en, rdata is zero.
- R5: For a read, the value of a pin is its stored value when the pin is an output. When the pin is an input, the value is pin_in after two synchronising flops: a change on pin_in is not seen by a read in the first two cycles after it, and is seen by a read issued two or more cycles after it.
- R6: The direction register is at offset 0x400. A write there loads all eight bits, where 1 makes the pin an output and 0 makes it an input. A read there returns the register, and pin_oe always equals it.
- R7: pin_out carries the stored data values for all pins, whatever their direction.
- R8: Any other address is undecoded: it reads as zero, and a write there changes neither pin_out nor pin_oe. This includes offsets whose two low bits are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 12 | Byte offset of the access |
| wr_en | input | 1 | Single-cycle write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Single-cycle read strobe |
| rdata | output | 8 | Registered read data, valid one cycle after rd_en |
| pin_in | input | 8 | Pin inputs (asynchronous) |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables, 1 = drive |

## Verification
Several properties are checked on every cycle:
- a data write never moves a pin outside its mask;
- a data read never returns a nonzero bit outside its mask;
- a direction write appears on pin_oe one cycle later;
- writes to undecoded offsets leave the outputs steady;
- rdata is zero after a cycle without rd_en.

Other behaviour can only be shown by the bench's scenarios, which compare against a model of the stored value:
- the exact values written and read for all 256 masks;
- how input and output pins mix in a read;
- the two-cycle latency of the synchroniser;
- zero reads from undecoded offsets.

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int PINS = 8,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic [PINS-1:0] wdata,
  input  logic            rd_en,
  output logic [PINS-1:0] rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe
);
  localparam int MLO = 2;
  localparam int MHI = PINS + 1;
  localparam logic [AW-1:0] DIR_OFS = AW'(1) << (PINS + 2);

  logic [PINS-1:0] out_q, dir_q, sync1, sync2;

  wire [PINS-1:0] mask     = addr[MHI:MLO];
  wire            data_sel = (addr[AW-1:PINS+2] == '0) && (addr[1:0] == 2'b00);
  wire            dir_sel  = (addr == DIR_OFS);
  wire [PINS-1:0] pin_val  = (dir_q & out_q) | (~dir_q & sync2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else if (wr_en) begin
      if (data_sel) out_q <= (out_q & ~mask) | (wdata & mask);
      if (dir_sel)  dir_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rdata <= '0;
    else if (rd_en && data_sel) rdata <= pin_val & mask;
    else if (rd_en && dir_sel)  rdata <= dir_q;
    else                        rdata <= '0;
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  // R3
  masked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && data_sel) |=> (((pin_out ^ $past(pin_out)) & ~$past(mask)) == '0));

  // R4
  masked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && data_sel) |=> ((rdata & ~$past(mask)) == '0));

  // R4
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));

  // R6
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dir_sel) |=> (pin_oe == $past(wdata)));

  // R8
  undecoded_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !data_sel && !dir_sel) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/gpio_mask_port_test.sv
`timescale 1ns/1ps
module gpio_mask_port_test;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [7:0] wdata = '0, pin_in = '0;
  logic [7:0] rdata, pin_out, pin_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_mask_port uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    addr = a; rd_en = 1;
    @(negedge clk);
    d = rdata;
    rd_en = 0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] model, r, exp;
    model = 0;
    repeat (3) @(negedge clk);
    check(pin_out == 0, "R1 pin_out", pin_out, 0);
    check(pin_oe == 0, "R1 pin_oe", pin_oe, 0);
    check(rdata == 0, "R1 rdata", rdata, 0);
    rst_n = 1;
    @(negedge clk);

    // R6: direction register
    wr(12'h400, 8'hFF);
    check(pin_oe == 8'hFF, "R6 oe", pin_oe, 8'hFF);
    rd(12'h400, r);
    check(r == 8'hFF, "R6 read", r, 8'hFF);
    @(negedge clk);
    check(rdata == 0, "R4 idle rdata", rdata, 0);

    // R2 R3 R7: every mask, all outputs
    for (int m = 0; m < 256; m++) begin
      logic [7:0] d;
      d = 8'((m * 37 + 11) & 255);
      wr(12'(m << 2), d);
      model = (model & ~8'(m)) | (d & 8'(m));
      check(pin_out == model, "R3 R7 pin_out", pin_out, model);
      rd(12'h3FC, r);
      check(r == model, "R2 R3 readback", r, model);
    end

    // R2 R3: single-pin writes of 0xFF / 0x00
    wr(12'h3FC, 8'h00); model = 0;
    for (int n = 0; n < 8; n++) begin
      wr(12'(1 << (n + 2)), 8'hFF);
      model[n] = 1'b1;
      check(pin_out == model, "R2 single-pin set", pin_out, model);
      rd(12'(1 << (n + 2)), r);
      check(r == (8'h1 << n), "R4 single-pin read", r, 8'h1 << n);
      if (n > 0) begin
        rd(12'(1 << (n + 1)), r);
        check(r != 0, "R4 neighbour high", r, 1);
      end
    end
    wr(12'h3FC, 8'h5A); model = 8'h5A;
    for (int n = 0; n < 8; n++) begin
      rd(12'(1 << (n + 2)), r);
      check((r != 0) == model[n], "R4 nonzero iff high", r, model[n]);
    end

    // R5 R4: all inputs, every mask
    wr(12'h400, 8'h00);
    pin_in = 8'hC3;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 256; m++) begin
      rd(12'(m << 2), r);
      exp = 8'hC3 & 8'(m);
      check(r == exp, "R4 R5 input read", r, exp);
    end

    // R5: mixed directions
    wr(12'h400, 8'hA5);
    pin_in = 8'h3C;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 256; m += 17) begin
      rd(12'(m << 2), r);
      exp = ((model & 8'hA5) | (8'h3C & 8'h5A)) & 8'(m);
      check(r == exp, "R5 mixed read", r, exp);
    end
    check(pin_out == model, "R7 out on inputs", pin_out, model);

    // R5: synchroniser latency
    wr(12'h400, 8'h00);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'hFF;
    rd(12'h3FC, r);
    check(r == 8'h00, "R5 sync first cycle", r, 0);
    rd(12'h3FC, r);
    check(r == 8'h00, "R5 sync second cycle", r, 0);
    rd(12'h3FC, r);
    check(r == 8'hFF, "R5 sync third cycle", r, 8'hFF);

    // R8: undecoded offsets
    foreach (r[i]) ;
    begin
      logic [11:0] bad [5] = '{12'h404, 12'h800, 12'hFFC, 12'h3FD, 12'h402};
      for (int k = 0; k < 5; k++) begin
        wr(bad[k], 8'hFF);
        check(pin_out == model, "R8 write ignored out", pin_out, model);
        check(pin_oe == 8'h00, "R8 write ignored oe", pin_oe, 0);
        rd(bad[k], r);
        check(r == 0, "R8 read zero", r, 0);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule